// File: doc/BRIEF.md
# Eight-Lane Wide Multiply Accumulator with Saturating Readout

This block holds one 48-bit signed accumulator for each of eight 16-bit lanes. Each operation it accepts multiplies the matching 16-bit lanes of two 128-bit operand vectors. The product either overwrites the lane or is added to it, and the block returns one 16-bit result per lane. That result is the new accumulator value shifted by a mode-dependent amount and then saturated. Four integer signedness modes are available, together with a doubled fractional mode that has two saturation flavours.

A separate read operation leaves the accumulator untouched. It returns a chosen 16-bit slice of every lane with no saturation, so software can spill the full wide state. Every accepted operation produces a registered result one cycle later. A read issued directly after an update sees the updated value.

Top module: `simd_acc`

## Requirements
- R1: While `rst_ni` is low, every accumulator lane is cleared, `res_o` is zero and `valid_o` is low. A read after reset returns zero in every lane.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. While `valid_i` is low, `res_o` and the accumulator hold their values.
- R3: When `op_i[3]` is 0 and `op_i[2:0]` names a multiply kind, the lane is replaced by the product.
- R4: When `op_i[3]` is 1 and `op_i[2:0]` names a multiply kind, the product is added to the lane modulo 2^48, with no saturation inside the accumulator.
- R5: The integer kinds are 4 (a unsigned, b unsigned), 5 (a signed, b unsigned), 6 (a unsigned, b signed) and 7 (both signed). For kinds 5 and 7, `res_o` is the signed clamp of the new lane value arithmetically shifted right by 16. For kinds 4 and 6, it is the signed clamp of the unshifted lane value.
- R6: Kind 0 multiplies both operands as signed and doubles the product. When replacing, it also adds 0x8000. `res_o` is the signed clamp of the new lane value shifted right by 16.
- R7: Kind 1 updates the lane exactly as kind 0 does, but applies an unsigned clamp: a negative value gives 0x0000, a value above 32767 gives 0xFFFF, and anything else passes through unchanged.
- R8: The signed clamp gives 0x8000 below -32768 and 0x7FFF above 32767. Otherwise it gives the low 16 bits of the value.
- R9: Kinds 2 and 3 are reads. `sel_i` picks the slice: 0 gives bits 15..0, 1 gives bits 31..16, and 2 or 3 give bits 47..32 of each lane. The slice is returned unclamped and the accumulator is unchanged.
- R10: Lane i uses only `a_i[16i+15:16i]` and `b_i[16i+15:16i]` and drives only `res_o[16i+15:16i]`.
- R11: An operation accepted in the cycle directly after an update acts on the updated accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Bit 3: accumulate; bits 2..0: kind |
| sel_i | input | 2 | Slice select for reads |
| a_i | input | 128 | First operand vector, eight 16-bit lanes |
| b_i | input | 128 | Second operand vector, eight 16-bit lanes |
| res_o | output | 128 | Registered per-lane result |
| valid_o | output | 1 | Result valid |

## Verification
Two functions can meet in the same cycle: an accumulator update, and the read or further update that consumes it. Operations are issued back to back on every clock, so a slice read or a multiply-accumulate lands in the cycle right after the update it depends on. The result is judged against a lane model and against hand-computed constants. A second meeting point is wrap-around and saturation inside a single update. A -1 lane is driven to zero by a carry that runs through all 48 bits, and accumulations that overshoot the 16-bit range are checked against their saturated values.

// File: rtl/simd_acc_pkg.sv
`timescale 1ns/1ps
package simd_acc_pkg;
  typedef enum logic [2:0] {
    K_FRAC  = 3'd0,
    K_FRACU = 3'd1,
    K_READ  = 3'd2,
    K_READ2 = 3'd3,
    K_UU    = 3'd4,
    K_SU    = 3'd5,
    K_US    = 3'd6,
    K_SS    = 3'd7
  } kind_e;

  typedef struct packed {
    logic  accum;
    kind_e kind;
  } op_t;
endpackage

// File: rtl/lane_mul.sv
`timescale 1ns/1ps
module lane_mul
  import simd_acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 48
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  op_t           op_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2*DW + 2;
  localparam logic [AW-1:0] RND = AW'(1) << (DW-1);

  logic a_sgn, b_sgn, frac;
  logic signed [DW:0] ax, bx;
  logic signed [PW-1:0] raw;
  logic [AW-1:0] ext;

  always_comb begin
    a_sgn = op_i.kind inside {K_FRAC, K_FRACU, K_SU, K_SS};
    b_sgn = op_i.kind inside {K_FRAC, K_FRACU, K_US, K_SS};
    frac  = op_i.kind inside {K_FRAC, K_FRACU};
    ax    = {a_sgn & a_i[DW-1], a_i};
    bx    = {b_sgn & b_i[DW-1], b_i};
    raw   = PW'(ax) * PW'(bx);
    ext   = {{(AW-PW){raw[PW-1]}}, raw};
    if (frac) prod_o = (ext << 1) + (op_i.accum ? '0 : RND);
    else      prod_o = ext;
  end
endmodule

// File: rtl/lane_clamp.sv
`timescale 1ns/1ps
module lane_clamp #(
  parameter int DW = 16,
  parameter int AW = 48
) (
  input  logic signed [AW-1:0] v_i,
  input  logic                 uns_i,
  output logic [DW-1:0]        y_o
);
  localparam logic signed [AW-1:0] HI_LIM = AW'(2**(DW-1) - 1);
  localparam logic signed [AW-1:0] LO_LIM = ~HI_LIM;

  always_comb begin
    if (uns_i) begin
      if (v_i < 0)           y_o = '0;
      else if (v_i > HI_LIM) y_o = '1;
      else                   y_o = v_i[DW-1:0];
    end else begin
      if (v_i < LO_LIM)      y_o = {1'b1, {(DW-1){1'b0}}};
      else if (v_i > HI_LIM) y_o = {1'b0, {(DW-1){1'b1}}};
      else                   y_o = v_i[DW-1:0];
    end
  end
endmodule

// File: rtl/acc_lane.sv
`timescale 1ns/1ps
module acc_lane
  import simd_acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  op_t           op_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int NSL = AW / DW;

  logic [AW-1:0] acc_q, prod, nxt;
  logic signed [AW-1:0] shv;
  logic [DW-1:0] clp, slice, res_q;
  logic is_read, upd, shift;
  int idx;

  lane_mul #(.DW(DW), .AW(AW)) u_mul (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .prod_o(prod)
  );

  always_comb begin
    is_read = op_i.kind inside {K_READ, K_READ2};
    upd     = valid_i && !is_read;
    shift   = op_i.kind inside {K_FRAC, K_FRACU, K_SU, K_SS};
    nxt     = op_i.accum ? acc_q + prod : prod;
    shv     = shift ? ($signed(nxt) >>> DW) : $signed(nxt);
    idx     = (int'(sel_i) >= NSL) ? NSL - 1 : int'(sel_i);
    slice   = acc_q[idx*DW +: DW];
  end

  lane_clamp #(.DW(DW), .AW(AW)) u_clamp (
    .v_i(shv), .uns_i(op_i.kind == K_FRACU), .y_o(clp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (valid_i) begin
      if (upd) acc_q <= nxt;
      res_q <= is_read ? slice : clp;
    end
  end

  assign res_o = res_q;

  AST_READ_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_read |=> $stable(acc_q)); // R9
  AST_LO_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_read && sel_i == 2'd0 |=> res_q == $past(acc_q[DW-1:0])); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q) && $stable(res_q)); // R2
  AST_UCLAMP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i.kind == K_FRACU && shv < 0 |=> res_q == '0); // R7
  AST_SCLAMP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i.kind == K_SS && shv > $signed(AW'(32767)) |=> res_q == 16'h7fff); // R8
endmodule

// File: rtl/simd_acc.sv
`timescale 1ns/1ps
module simd_acc
  import simd_acc_pkg::*;
#(
  parameter int NLANES = 8,
  parameter int DW     = 16,
  parameter int AW     = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [3:0]           op_i,
  input  logic [1:0]           sel_i,
  input  logic [NLANES*DW-1:0] a_i,
  input  logic [NLANES*DW-1:0] b_i,
  output logic [NLANES*DW-1:0] res_o,
  output logic                 valid_o
);
  op_t  op;
  logic valid_q;

  assign op = op_t'(op_i);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    acc_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .op_i   (op),
      .sel_i  (sel_i),
      .a_i    (a_i[g*DW +: DW]),
      .b_i    (b_i[g*DW +: DW]),
      .res_o  (res_o[g*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
endmodule

// File: tb/simd_acc_bench.sv
`timescale 1ns/1ps
module simd_acc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] sel = '0;
  logic [127:0] a = '0, b = '0;
  logic [127:0] res;
  logic vout;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [47:0] acc_m [8];

  always #2.5 clk = ~clk;

  simd_acc u_simd_acc (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .op_i(op), .sel_i(sel),
    .a_i(a), .b_i(b), .res_o(res), .valid_o(vout)
  );

  typedef struct packed {
    logic [3:0]   op;
    logic [1:0]   sel;
    logic [127:0] a;
    logic [127:0] b;
  } vec_t;

  localparam logic [127:0] VA = 128'h7fff_8000_0001_ffff_1234_edcc_4000_c000;
  localparam logic [127:0] VB = 128'h7fff_7fff_ffff_ffff_0002_0100_8000_4000;

  localparam vec_t TBL [12] = '{
    '{4'h7, 2'd0, VA, VB},
    '{4'hF, 2'd0, VB, VA},
    '{4'h2, 2'd1, VA, VB},
    '{4'h0, 2'd0, VA, VB},
    '{4'h8, 2'd0, VA, VA},
    '{4'h1, 2'd0, VB, VA},
    '{4'h4, 2'd0, VA, VB},
    '{4'h2, 2'd2, VA, VB},
    '{4'h5, 2'd0, VB, VA},
    '{4'hC, 2'd0, VA, VA},
    '{4'h6, 2'd0, VA, VB},
    '{4'h3, 2'd0, VA, VB}
  };

  function automatic logic [127:0] rep(input logic [15:0] x);
    return {8{x}};
  endfunction

  function automatic logic [15:0] sclamp(input longint v);
    if (v < -32768) return 16'h8000;
    if (v > 32767)  return 16'h7fff;
    return v[15:0];
  endfunction

  function automatic logic [15:0] uclamp(input longint v);
    if (v < 0)     return 16'h0000;
    if (v > 32767) return 16'hffff;
    return v[15:0];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one op at a negedge, sample at the following negedge
  task automatic issue(input logic [3:0] o, input logic [1:0] s,
                       input logic [127:0] x, input logic [127:0] y, input string req);
    logic [127:0] exp;
    exp = '0;
    for (int l = 0; l < 8; l++) begin
      logic [2:0] k;
      logic [15:0] xa, yb;
      longint px, py, p, v;
      logic [47:0] n;
      int idx;
      k = o[2:0];
      xa = x[16*l +: 16];
      yb = y[16*l +: 16];
      if (k == 3'd2 || k == 3'd3) begin
        idx = (s > 2'd2) ? 2 : int'(s);
        exp[16*l +: 16] = acc_m[l][16*idx +: 16];
      end else begin
        px = (k == 3'd4 || k == 3'd6) ? longint'(xa) : longint'($signed(xa));
        py = (k == 3'd4 || k == 3'd5) ? longint'(yb) : longint'($signed(yb));
        p = px * py;
        if (k < 3'd2) begin
          p = p * 2;
          if (!o[3]) p = p + 32768;
        end
        n = o[3] ? acc_m[l] + p[47:0] : p[47:0];
        v = longint'($signed(n));
        if (k != 3'd4 && k != 3'd6) v = v >>> 16;
        exp[16*l +: 16] = (k == 3'd1) ? uclamp(v) : sclamp(v);
        acc_m[l] = n;
      end
    end
    op = o; sel = s; a = x; b = y; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk({req, " valid"}, {127'b0, vout}, 128'd1);
    chk(req, res, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    for (int l = 0; l < 8; l++) acc_m[l] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset res", res, '0);
    chk("R1 reset valid", {127'b0, vout}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(4'h2, 2'd2, '0, '0, "R1 read after reset");
    chk("R1 zero hi", res, '0);

    // table walk, model-checked
    for (int i = 0; i < 12; i++)
      issue(TBL[i].op, TBL[i].sel, TBL[i].a, TBL[i].b, "R10 table");

    // R5 integer signed
    issue(4'h7, 2'd0, rep(16'h7fff), rep(16'h7fff), "R5 ss");
    chk("R5 ss lit", res, rep(16'h3fff));
    issue(4'h7, 2'd0, rep(16'h8000), rep(16'h8000), "R3 replace");
    chk("R3 lit", res, rep(16'h4000));
    issue(4'hF, 2'd0, rep(16'h8000), rep(16'h8000), "R8 top");
    chk("R8 top lit", res, rep(16'h7fff));
    issue(4'h7, 2'd0, rep(16'h8000), rep(16'h7fff), "R8 neg");
    chk("R8 neg lit", res, rep(16'hc000));
    issue(4'hF, 2'd0, rep(16'h8000), rep(16'h7fff), "R4 mac");
    chk("R4 mac lit", res, rep(16'h8001));
    issue(4'hF, 2'd0, rep(16'h8000), rep(16'h7fff), "R8 bottom");
    chk("R8 bottom lit", res, rep(16'h8000));

    // R7 / R6 fractional
    issue(4'h1, 2'd0, rep(16'h8000), rep(16'h8000), "R7 over");
    chk("R7 over lit", res, rep(16'hffff));
    issue(4'h1, 2'd0, rep(16'h8000), rep(16'h4000), "R7 neg");
    chk("R7 neg lit", res, rep(16'h0000));
    issue(4'h1, 2'd0, rep(16'h7fff), rep(16'h7fff), "R7 pass");
    chk("R7 pass lit", res, rep(16'h7ffe));
    issue(4'h0, 2'd0, rep(16'h8000), rep(16'h8000), "R6 sat");
    chk("R6 sat lit", res, rep(16'h7fff));
    issue(4'h0, 2'd0, rep(16'h0001), rep(16'h0001), "R6 small");
    chk("R6 small lit", res, rep(16'h0000));
    issue(4'h2, 2'd0, '0, '0, "R6 round");
    chk("R6 round lit", res, rep(16'h8002));

    // R5 unsigned kinds and R9 slices
    issue(4'h4, 2'd0, rep(16'hffff), rep(16'hffff), "R5 uu");
    chk("R5 uu lit", res, rep(16'h7fff));
    issue(4'h2, 2'd0, rep(16'h1234), rep(16'h5678), "R9 lo");
    chk("R9 lo lit", res, rep(16'h0001));
    issue(4'h3, 2'd1, '0, '0, "R9 mid");
    chk("R9 mid lit", res, rep(16'hfffe));
    issue(4'h2, 2'd2, '0, '0, "R9 hi");
    chk("R9 hi lit", res, rep(16'h0000));
    issue(4'h2, 2'd3, '0, '0, "R9 sel3");
    chk("R9 sel3 lit", res, rep(16'h0000));
    issue(4'h2, 2'd1, '0, '0, "R9 unchanged");
    chk("R9 unchanged lit", res, rep(16'hfffe));
    issue(4'h5, 2'd0, rep(16'h0002), rep(16'hffff), "R5 su");
    chk("R5 su lit", res, rep(16'h0001));
    issue(4'h6, 2'd0, rep(16'h0002), rep(16'hffff), "R5 us");
    chk("R5 us lit", res, rep(16'hfffe));

    // R4 wrap through 48 bits
    issue(4'h7, 2'd0, rep(16'hffff), rep(16'h0001), "R4 minus one");
    chk("R4 minus one lit", res, rep(16'hffff));
    issue(4'h2, 2'd2, '0, '0, "R4 hi ones");
    chk("R4 hi ones lit", res, rep(16'hffff));
    issue(4'hF, 2'd0, rep(16'h0001), rep(16'h0001), "R4 wrap");
    chk("R4 wrap lit", res, rep(16'h0000));
    issue(4'h2, 2'd2, '0, '0, "R4 wrap hi");
    chk("R4 wrap hi lit", res, rep(16'h0000));

    // R10 lane separation
    issue(4'h4, 2'd0, 128'h0001_0002_0003_0004_0005_0006_0007_0008, rep(16'h0003), "R10 lanes");
    chk("R10 lanes lit", res, 128'h0003_0006_0009_000c_000f_0012_0015_0018);

    // R11 back to back
    issue(4'h4, 2'd0, rep(16'h0002), rep(16'h0002), "R11 set");
    issue(4'hC, 2'd0, rep(16'h0003), rep(16'h0003), "R11 mac");
    issue(4'h2, 2'd0, '0, '0, "R11 read");
    chk("R11 read lit", res, rep(16'h000d));

    // R2 idle hold
    held = res;
    a = rep(16'h7777); b = rep(16'h7777); op = 4'h4;
    @(negedge clk);
    chk("R2 idle valid", {127'b0, vout}, '0);
    chk("R2 idle res", res, held);
    issue(4'h2, 2'd0, '0, '0, "R2 acc held");
    chk("R2 acc held lit", res, rep(16'h000d));

    // R1 reset mid-run
    rst_n = 1'b0;
    for (int l = 0; l < 8; l++) acc_m[l] = '0;
    @(negedge clk);
    chk("R1 mid reset res", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(4'h2, 2'd0, '0, '0, "R1 cleared");
    chk("R1 cleared lit", res, '0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule